// File: doc/BRIEF.md
# Keypad Controller Command Decoder

This block sits behind the byte layer of a two-wire control bus and turns the byte stream into register accesses. A write transaction begins with an opcode byte that selects a command; any further bytes in that transaction are parameters for that command. A read transaction returns response bytes for whichever command the last write selected. The decoder holds the keypad and port settings: configuration, clock setup, active time, debounce time, keypad geometry, and the port direction, port level and pull-select words. It also holds an interrupt status byte and an error byte, and it drives an active-low interrupt line.

Every parameter is checked against the rules of its command. Once a command has received all of its parameters, the stored opcode changes to a done marker (0xFF). Any extra byte after that is reported as a bad parameter. Opcodes that the decoder does not know are reported through their own error bit. The bus framing is handled outside the block and arrives as single-cycle strobes: transaction start with a direction flag, byte received, and byte requested. Read data comes back registered, one cycle after the request.

Top module: `kbd_cmd_decoder`

## Requirements
- R1: After synchronous reset, the settings hold these values: configuration 0x80, clock 0x08, active time 125, debounce 3, keypad size 0x33. The status byte is 0x10 (bit 4 means not yet initialised). The error byte and all three port words are 0.
- R2: `irq_n` is low exactly when the status byte is nonzero.
- R3: A transaction start resets the byte index. The first byte received in a write transaction loads the opcode, and later bytes are parameters with index 0, 1, and so on. Received bytes are ignored in a read transaction. Byte requests are ignored in a write transaction and produce no `rd_valid`.
- R4: Opcode 0x81 with one parameter stores the configuration, clears the status byte and sets the opcode to 0xFF.
- R5: Opcode 0x83 with parameter 0xAA restores the configuration, clock, active time, debounce, keypad size and status values of R1, and leaves the error byte and port words unchanged. Any other parameter value is a bad parameter.
- R6: The error byte has bad parameter at bit 0 and unknown opcode at bit 1. Any parameter byte sent while the opcode is 0xFF is a bad parameter. Any error also sets status bit 3. Error bits stay set until the hardware reset.
- R7: Opcode 0x90 stores the keypad size. The value is a bad parameter when its low nibble is outside 3..12 or its high nibble is outside 3..8. The value is stored either way.
- R8: Opcode 0x8F stores the debounce time, and a value of 0 is a bad parameter. Opcode 0x93 stores the clock value, and low two bits of 01 or 10 are a bad parameter. Opcode 0x8B stores any active-time value without error.
- R9: Opcodes 0x84 (pull), 0x85 (direction) and 0x86 (level) take the low byte first, which also clears the high byte, and then the high byte. After the high byte the opcode becomes 0xFF. Reads with opcode 0x87 return the direction word and reads with 0x88 return the level word, low byte first, with 0x00 after that.
- R10: A read with opcode 0x82 returns the status byte at index 0 and 0x00 after that. Each such read clears the status byte unless bit 4 is set.
- R11: Read responses by opcode:
  - 0x80 returns 0x00, then 0x04, then 0x00.
  - 0x92 returns the configuration AND 0x0F.
  - 0x94 returns (clock AND 0xFC) OR 0x02.
  - 0x91 returns the keypad size.
  - 0x8C returns the error byte.
- R12: A read request while the opcode is unknown, or is 0xFF, returns 0x00 and sets the unknown-opcode error.
- R13: `rd_data` and a one-cycle `rd_valid` appear one clock after an accepted byte request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Transaction start strobe |
| tx_write | input | 1 | Direction at start: 1 = write, 0 = read |
| rx_valid | input | 1 | Byte received strobe |
| rx_data | input | 8 | Received byte |
| rd_req | input | 1 | Byte requested strobe |
| rd_data | output | 8 | Response byte |
| rd_valid | output | 1 | Response byte valid |
| irq_n | output | 1 | Active-low interrupt |
| cfg_o | output | 8 | Configuration setting |
| clk_cfg_o | output | 8 | Clock setting |
| act_time_o | output | 8 | Active time setting |
| debounce_o | output | 8 | Debounce setting |
| keypad_size_o | output | 8 | Keypad geometry (columns in the high nibble, rows in the low nibble) |
| gpio_dir_o | output | GPIO_W | Port direction word |
| gpio_state_o | output | GPIO_W | Port level word |
| gpio_pull_o | output | GPIO_W | Port pull-select word |

## Verification
The assertions check several rules on every clock cycle:
- the interrupt line follows the status byte;
- error bits never drop;
- a parameter byte sent after the done marker always flags a bad parameter;
- a configuration write always clears status;
- the not-initialised bit survives status reads;
- the byte index restarts and advances correctly;
- a read response follows each accepted request.

The scenarios in the bench are needed for the rest. They cover the exact response bytes of each read opcode, the range limits for keypad size, debounce and clock, and the two-byte port writes. They also cover which values a soft reset restores and which it keeps, and the rule that bytes arriving against the current direction are ignored.

// File: rtl/kcmd_pkg.sv
package kcmd_pkg;
  localparam logic [7:0] OP_ID_RD    = 8'h80;
  localparam logic [7:0] OP_CFG_WR   = 8'h81;
  localparam logic [7:0] OP_STAT_RD  = 8'h82;
  localparam logic [7:0] OP_SOFT_RST = 8'h83;
  localparam logic [7:0] OP_PULL_WR  = 8'h84;
  localparam logic [7:0] OP_DIR_WR   = 8'h85;
  localparam logic [7:0] OP_LVL_WR   = 8'h86;
  localparam logic [7:0] OP_DIR_RD   = 8'h87;
  localparam logic [7:0] OP_LVL_RD   = 8'h88;
  localparam logic [7:0] OP_ACT_WR   = 8'h8B;
  localparam logic [7:0] OP_ERR_RD   = 8'h8C;
  localparam logic [7:0] OP_DEB_WR   = 8'h8F;
  localparam logic [7:0] OP_SIZE_WR  = 8'h90;
  localparam logic [7:0] OP_SIZE_RD  = 8'h91;
  localparam logic [7:0] OP_CFG_RD   = 8'h92;
  localparam logic [7:0] OP_CLK_WR   = 8'h93;
  localparam logic [7:0] OP_CLK_RD   = 8'h94;
  localparam logic [7:0] OP_DONE     = 8'hFF;

  localparam logic [7:0]  SOFT_RST_KEY = 8'hAA;
  localparam logic [15:0] ID_WORD      = 16'h0400;

  localparam int ST_ERR     = 3;
  localparam int ST_UNINIT  = 4;
  localparam int ER_BADPAR  = 0;
  localparam int ER_UNKNOWN = 1;
endpackage

// File: rtl/kcmd_bytecnt.sv
module kcmd_bytecnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  output logic [CNT_W-1:0] idx
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                     idx <= '0;
    else if (start)              idx <= '0;
    else if (step && idx != TOP) idx <= idx + 1'b1;
  end

  assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> idx == '0);
  assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (!start && step && idx != TOP) |=> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/kcmd_param_check.sv
module kcmd_param_check
  import kcmd_pkg::*;
#(
  parameter int MIN_DIM  = 3,
  parameter int MAX_ROWS = 12,
  parameter int MAX_COLS = 8
) (
  input  logic [7:0] op,
  input  logic [7:0] val,
  output logic       bad
);
  localparam logic [3:0] DIM_LO  = 4'(MIN_DIM);
  localparam logic [3:0] ROW_HI  = 4'(MAX_ROWS);
  localparam logic [3:0] COL_HI  = 4'(MAX_COLS);

  logic [3:0] rows, cols;

  always_comb begin
    rows = val[3:0];
    cols = val[7:4];
    case (op)
      OP_SOFT_RST: bad = (val != SOFT_RST_KEY);
      OP_DEB_WR:   bad = (val == 8'h00);
      OP_SIZE_WR:  bad = (rows < DIM_LO) || (rows > ROW_HI) ||
                         (cols < DIM_LO) || (cols > COL_HI);
      OP_CLK_WR:   bad = val[1] ^ val[0];
      default:     bad = 1'b0;
    endcase
  end
endmodule

// File: rtl/kcmd_readmux.sv
module kcmd_readmux
  import kcmd_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int GPIO_W = 16
) (
  input  logic [7:0]        op,
  input  logic [CNT_W-1:0]  idx,
  input  logic [7:0]        cfg,
  input  logic [7:0]        clk_cfg,
  input  logic [7:0]        size,
  input  logic [7:0]        status,
  input  logic [7:0]        err,
  input  logic [GPIO_W-1:0] dir,
  input  logic [GPIO_W-1:0] lvl,
  output logic [7:0]        data,
  output logic              unknown
);
  localparam int GPIO_BYTES = GPIO_W / 8;

  function automatic logic [7:0] pick(input logic [GPIO_W-1:0] w, input logic [CNT_W-1:0] b);
    logic [7:0] r;
    r = 8'h00;
    for (int k = 0; k < GPIO_BYTES; k++)
      if (b == CNT_W'(k)) r = w[8*k +: 8];
    return r;
  endfunction

  always_comb begin
    data    = 8'h00;
    unknown = 1'b0;
    case (op)
      OP_ID_RD: begin
        if (idx == CNT_W'(0))      data = ID_WORD[7:0];
        else if (idx == CNT_W'(1)) data = ID_WORD[15:8];
      end
      OP_STAT_RD: if (idx == '0) data = status;
      OP_DIR_RD:  data = pick(dir, idx);
      OP_LVL_RD:  data = pick(lvl, idx);
      OP_ERR_RD:  data = err;
      OP_SIZE_RD: data = size;
      OP_CFG_RD:  data = {4'h0, cfg[3:0]};
      OP_CLK_RD:  data = {clk_cfg[7:2], 2'b10};
      default:    unknown = 1'b1;
    endcase
  end
endmodule

// File: rtl/kbd_cmd_decoder.sv
module kbd_cmd_decoder
  import kcmd_pkg::*;
#(
  parameter int         CNT_W    = 3,
  parameter int         GPIO_W   = 16,
  parameter int         MIN_DIM  = 3,
  parameter int         MAX_ROWS = 12,
  parameter int         MAX_COLS = 8,
  parameter logic [7:0] CFG_RST  = 8'h80,
  parameter logic [7:0] CLK_RST  = 8'h08,
  parameter logic [7:0] ACT_RST  = 8'd125,
  parameter logic [7:0] DEB_RST  = 8'd3,
  parameter logic [7:0] SIZE_RST = 8'h33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_start,
  input  logic              tx_write,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rd_req,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              irq_n,
  output logic [7:0]        cfg_o,
  output logic [7:0]        clk_cfg_o,
  output logic [7:0]        act_time_o,
  output logic [7:0]        debounce_o,
  output logic [7:0]        keypad_size_o,
  output logic [GPIO_W-1:0] gpio_dir_o,
  output logic [GPIO_W-1:0] gpio_state_o,
  output logic [GPIO_W-1:0] gpio_pull_o
);
  localparam int         GPIO_BYTES = GPIO_W / 8;
  localparam logic [7:0] STATUS_RST = 8'(1 << ST_UNINIT);

  logic [7:0]        op_q, op_d, status_q, status_d, err_q, err_d;
  logic [7:0]        cfg_d, clk_d, act_d, deb_d, size_d;
  logic [GPIO_W-1:0] dir_d, lvl_d, pull_d;
  logic              wr_mode_q;
  logic [CNT_W-1:0]  idx, widx;
  logic              wr_fire, rd_fire, par_bad, rd_unknown;
  logic [7:0]        rd_mux, rd_data_d;
  logic [1:0]        err_hit;

  assign wr_fire = !tx_start && rx_valid && wr_mode_q;
  assign rd_fire = !tx_start && !rx_valid && rd_req && !wr_mode_q;
  assign widx    = idx - 1'b1;

  kcmd_bytecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start(tx_start), .step(wr_fire || rd_fire), .idx(idx)
  );

  kcmd_param_check #(.MIN_DIM(MIN_DIM), .MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS)) u_chk (
    .op(op_q), .val(rx_data), .bad(par_bad)
  );

  kcmd_readmux #(.CNT_W(CNT_W), .GPIO_W(GPIO_W)) u_rmux (
    .op(op_q), .idx(idx), .cfg(cfg_o), .clk_cfg(clk_cfg_o), .size(keypad_size_o),
    .status(status_q), .err(err_q), .dir(gpio_dir_o), .lvl(gpio_state_o),
    .data(rd_mux), .unknown(rd_unknown)
  );

  function automatic logic [GPIO_W-1:0] put_byte(input logic [GPIO_W-1:0] cur,
                                                 input logic [CNT_W-1:0] b,
                                                 input logic [7:0] v);
    logic [GPIO_W-1:0] r;
    r = (b == '0) ? '0 : cur;
    for (int k = 0; k < GPIO_BYTES; k++)
      if (b == CNT_W'(k)) r[8*k +: 8] = v;
    return r;
  endfunction

  always_comb begin
    op_d      = op_q;
    status_d  = status_q;
    err_d     = err_q;
    cfg_d     = cfg_o;
    clk_d     = clk_cfg_o;
    act_d     = act_time_o;
    deb_d     = debounce_o;
    size_d    = keypad_size_o;
    dir_d     = gpio_dir_o;
    lvl_d     = gpio_state_o;
    pull_d    = gpio_pull_o;
    rd_data_d = rd_data;
    err_hit   = '0;

    if (wr_fire) begin
      if (idx == '0) begin
        op_d = rx_data;
      end else begin
        case (op_q)
          OP_CFG_WR: begin
            cfg_d    = rx_data;
            status_d = '0;
            op_d     = OP_DONE;
          end
          OP_SOFT_RST: begin
            op_d = OP_DONE;
            if (par_bad) err_hit[ER_BADPAR] = 1'b1;
            else begin
              cfg_d    = CFG_RST;
              clk_d    = CLK_RST;
              act_d    = ACT_RST;
              deb_d    = DEB_RST;
              size_d   = SIZE_RST;
              status_d = STATUS_RST;
            end
          end
          OP_PULL_WR, OP_DIR_WR, OP_LVL_WR: begin
            if (op_q == OP_PULL_WR)     pull_d = put_byte(gpio_pull_o, widx, rx_data);
            else if (op_q == OP_DIR_WR) dir_d  = put_byte(gpio_dir_o, widx, rx_data);
            else                        lvl_d  = put_byte(gpio_state_o, widx, rx_data);
            if (widx == CNT_W'(GPIO_BYTES - 1)) op_d = OP_DONE;
          end
          OP_ACT_WR: begin
            act_d = rx_data;
            op_d  = OP_DONE;
          end
          OP_DEB_WR, OP_SIZE_WR, OP_CLK_WR: begin
            if (op_q == OP_DEB_WR)       deb_d  = rx_data;
            else if (op_q == OP_SIZE_WR) size_d = rx_data;
            else                         clk_d  = rx_data;
            op_d = OP_DONE;
            if (par_bad) err_hit[ER_BADPAR] = 1'b1;
          end
          OP_DONE: err_hit[ER_BADPAR]  = 1'b1;
          default: err_hit[ER_UNKNOWN] = 1'b1;
        endcase
      end
    end else if (rd_fire) begin
      rd_data_d = rd_mux;
      if (rd_unknown) err_hit[ER_UNKNOWN] = 1'b1;
      if (op_q == OP_STAT_RD && !status_q[ST_UNINIT]) status_d = '0;
    end

    if (|err_hit) begin
      err_d            = err_q | {6'b0, err_hit};
      status_d[ST_ERR] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q          <= OP_DONE;
      status_q      <= STATUS_RST;
      err_q         <= '0;
      cfg_o         <= CFG_RST;
      clk_cfg_o     <= CLK_RST;
      act_time_o    <= ACT_RST;
      debounce_o    <= DEB_RST;
      keypad_size_o <= SIZE_RST;
      gpio_dir_o    <= '0;
      gpio_state_o  <= '0;
      gpio_pull_o   <= '0;
      wr_mode_q     <= 1'b0;
      rd_data       <= '0;
      rd_valid      <= 1'b0;
      irq_n         <= ~|STATUS_RST;
    end else begin
      op_q          <= op_d;
      status_q      <= status_d;
      err_q         <= err_d;
      cfg_o         <= cfg_d;
      clk_cfg_o     <= clk_d;
      act_time_o    <= act_d;
      debounce_o    <= deb_d;
      keypad_size_o <= size_d;
      gpio_dir_o    <= dir_d;
      gpio_state_o  <= lvl_d;
      gpio_pull_o   <= pull_d;
      if (tx_start) wr_mode_q <= tx_write;
      rd_data       <= rd_data_d;
      rd_valid      <= rd_fire;
      irq_n         <= ~|status_d;
    end
  end

  assert_irq_level_R2: assert property (@(posedge clk) disable iff (rst)
    irq_n == (status_q == 8'h00));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((err_q & $past(err_q)) == $past(err_q)));
  assert_done_badpar_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && idx != '0 && op_q == OP_DONE) |=> (err_q[ER_BADPAR] && status_q[ST_ERR]));
  assert_cfg_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && idx != '0 && op_q == OP_CFG_WR) |=> (op_q == OP_DONE && status_q == 8'h00));
  assert_uninit_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && op_q == OP_STAT_RD && status_q[ST_UNINIT]) |=> status_q[ST_UNINIT]);
  assert_rd_follow_R13: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !tx_start && !rx_valid && !wr_mode_q) |=> rd_valid);
  assert_rd_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
endmodule

// File: tb/sim_kbd_cmd_decoder.sv
module sim_kbd_cmd_decoder;
  logic clk = 1'b0, rst = 1'b1;
  logic tx_start = 0, tx_write = 0, rx_valid = 0, rd_req = 0;
  logic [7:0] rx_data = 0;
  logic [7:0] rd_data, cfg_o, clk_cfg_o, act_time_o, debounce_o, keypad_size_o;
  logic rd_valid, irq_n;
  logic [15:0] gpio_dir_o, gpio_state_o, gpio_pull_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  kbd_cmd_decoder u0 (
    .clk(clk), .rst(rst), .tx_start(tx_start), .tx_write(tx_write),
    .rx_valid(rx_valid), .rx_data(rx_data), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq_n(irq_n),
    .cfg_o(cfg_o), .clk_cfg_o(clk_cfg_o), .act_time_o(act_time_o),
    .debounce_o(debounce_o), .keypad_size_o(keypad_size_o),
    .gpio_dir_o(gpio_dir_o), .gpio_state_o(gpio_state_o), .gpio_pull_o(gpio_pull_o)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected response bytes
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 unexpected response act=%0h exp=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s act=%0h exp=%0h", t, rd_data, e);
        end
      end
    end
  end

  task automatic tstart(bit w);
    @(negedge clk); tx_start = 1; tx_write = w;
    @(negedge clk); tx_start = 0;
  endtask
  task automatic sendb(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask
  task automatic rdb(logic [7:0] e, string t);
    @(negedge clk); exp_q.push_back(e); tag_q.push_back(t); rd_req = 1;
    @(negedge clk); rd_req = 0;
  endtask
  task automatic wr(logic [7:0] op, logic [7:0] v);
    tstart(1); sendb(op); sendb(v);
  endtask
  task automatic rdsel(logic [7:0] op);
    tstart(1); sendb(op); tstart(0);
  endtask
  task automatic clr(logic [7:0] e);
    rdsel(8'h82); rdb(e, "R10 status clear read");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset values
    chk("R1 cfg", cfg_o, 16'h80);
    chk("R1 clk", clk_cfg_o, 16'h08);
    chk("R1 act", act_time_o, 16'd125);
    chk("R1 deb", debounce_o, 16'd3);
    chk("R1 size", keypad_size_o, 16'h33);
    chk("R1 dir", gpio_dir_o, 16'h0);
    chk("R2 irq low at reset", irq_n, 16'h0);
    rdsel(8'h8C); rdb(8'h00, "R1 error byte zero");
    rdsel(8'h82); rdb(8'h10, "R10 status uninit"); rdb(8'h00, "R10 status byte1");
    tstart(0); rdb(8'h10, "R10 uninit not cleared");
    chk("R2 irq still low", irq_n, 16'h0);

    // R4 configuration write
    wr(8'h81, 8'hA5);
    chk("R4 cfg stored", cfg_o, 16'hA5);
    chk("R2 irq high after clear", irq_n, 16'h1);
    rdsel(8'h92); rdb(8'h05, "R11 cfg read masked");
    tstart(1); sendb(8'h81); sendb(8'h3C); sendb(8'h11);
    chk("R4 cfg second", cfg_o, 16'h3C);
    chk("R6 extra byte raises irq", irq_n, 16'h0);
    rdsel(8'h82); rdb(8'h08, "R6 status error bit");
    chk("R10 irq high after read", irq_n, 16'h1);
    tstart(0); rdb(8'h00, "R10 status now zero");

    // R12 read with done marker
    wr(8'h81, 8'h3C);
    tstart(0); rdb(8'h00, "R12 read on done marker");
    chk("R12 irq low", irq_n, 16'h0);
    rdsel(8'h8C); rdb(8'h03, "R6 error bits");
    clr(8'h08);
    wr(8'h8D, 8'h00);
    chk("R6 unknown write flags", irq_n, 16'h0);
    clr(8'h08);

    // R7 keypad size
    wr(8'h90, 8'h2C);
    chk("R7 bad size stored", keypad_size_o, 16'h2C);
    chk("R7 bad size flags", irq_n, 16'h0);
    clr(8'h08);
    wr(8'h90, 8'h8C);
    chk("R7 max size ok", irq_n, 16'h1);
    rdsel(8'h91); rdb(8'h8C, "R11 size read");
    wr(8'h90, 8'h3D);
    chk("R7 rows 13 flags", irq_n, 16'h0);
    clr(8'h08);

    // R8 active, debounce, clock
    wr(8'h8B, 8'h00);
    chk("R8 act zero ok", irq_n, 16'h1);
    chk("R8 act stored", act_time_o, 16'h00);
    wr(8'h8F, 8'h00);
    chk("R8 deb zero flags", irq_n, 16'h0);
    clr(8'h08);
    wr(8'h8F, 8'h01);
    chk("R8 deb one ok", irq_n, 16'h1);
    wr(8'h93, 8'hF7);
    chk("R8 clk 11 ok", irq_n, 16'h1);
    rdsel(8'h94); rdb(8'hF6, "R11 clock read");
    wr(8'h93, 8'h01);
    chk("R8 clk 01 flags", irq_n, 16'h0);
    clr(8'h08);

    // R9 port words
    tstart(1); sendb(8'h85); sendb(8'h34); sendb(8'h12);
    chk("R9 dir word", gpio_dir_o, 16'h1234);
    chk("R9 no error", irq_n, 16'h1);
    rdsel(8'h87); rdb(8'h34, "R9 dir low"); rdb(8'h12, "R9 dir high"); rdb(8'h00, "R9 dir beyond");
    tstart(1); sendb(8'h86); sendb(8'hAB); sendb(8'hCD);
    rdsel(8'h88); rdb(8'hAB, "R9 lvl low"); rdb(8'hCD, "R9 lvl high");
    tstart(1); sendb(8'h84); sendb(8'h55); sendb(8'h66);
    chk("R9 pull word", gpio_pull_o, 16'h6655);
    wr(8'h85, 8'h77);
    chk("R9 low byte clears high", gpio_dir_o, 16'h0077);
    tstart(1); sendb(8'h85); sendb(8'h01); sendb(8'h02); sendb(8'h03);
    chk("R9 third byte flags", irq_n, 16'h0);
    chk("R9 dir kept", gpio_dir_o, 16'h0201);
    clr(8'h08);

    // R11 id
    rdsel(8'h80); rdb(8'h00, "R11 id byte0"); rdb(8'h04, "R11 id byte1"); rdb(8'h00, "R11 id byte2");

    // R3 restart and direction gating
    tstart(1); sendb(8'h8F);
    tstart(1); sendb(8'h8B); sendb(8'h40);
    chk("R3 restart act", act_time_o, 16'h40);
    chk("R3 restart deb kept", debounce_o, 16'h01);
    tstart(0); sendb(8'h81); sendb(8'h00);
    chk("R3 rx ignored in read", cfg_o, 16'h3C);
    tstart(1);
    @(negedge clk); rd_req = 1; @(negedge clk); rd_req = 0;
    @(negedge clk);
    chk("R3 req ignored in write", irq_n, 16'h1);

    // R5 soft reset
    wr(8'h83, 8'h55);
    chk("R5 bad key flags", irq_n, 16'h0);
    clr(8'h08);
    wr(8'h83, 8'hAA);
    chk("R5 cfg", cfg_o, 16'h80);
    chk("R5 act", act_time_o, 16'd125);
    chk("R5 deb", debounce_o, 16'd3);
    chk("R5 size", keypad_size_o, 16'h33);
    chk("R5 clk", clk_cfg_o, 16'h08);
    chk("R5 dir kept", gpio_dir_o, 16'h0201);
    rdsel(8'h82); rdb(8'h10, "R5 status uninit");
    rdsel(8'h8C); rdb(8'h03, "R6 error survives soft reset");
    wr(8'h81, 8'h00);
    chk("R4 clears uninit", irq_n, 16'h1);

    // R6 hardware reset clears error
    @(negedge clk); rst = 1; repeat (2) @(negedge clk); rst = 0;
    rdsel(8'h8C); rdb(8'h00, "R6 error cleared by reset");
    chk("R1 dir after reset", gpio_dir_o, 16'h0);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R13 missing responses act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule